// File: doc/BRIEF.md
# Pending Interrupt Identifier Resolver

This block sits behind a banked interrupt controller that keeps one summary word and two full bank words of pending lines. Each clock it looks at all three words and works out which single interrupt should be serviced next. The result is a seven-bit identifier plus a valid flag, both registered, so software or a downstream dispatcher sees the answer one clock after the words were sampled.

The summary word holds three kinds of bits. A group of eight basic lines is serviced directly from bank 0. Eleven shortcut bits stand for frequently used lines that really live in bank 1 or bank 2; a fixed table turns a shortcut back into its home line number. Two cascade bits only say "look in bank 1" or "look in bank 2", and the resolver then takes the lowest pending line of that bank's full word. Groups are served in a fixed order, and inside a group the lowest set bit wins.

Top module: `pir_resolver`

## Requirements
- R1: A synchronous active-high reset forces `irq_valid` to 0 and `irq_id` to 7'h7F at the next clock edge, whatever the inputs are.
- R2: The identifier is the bank number in bits 6:5 and the line number inside that bank in bits 4:0; it appears one clock edge after the input words are presented.
- R3: Summary bits 31 down to 21 have no effect on the output.
- R4: When none of summary bits 0 to 20 is set, `irq_valid` is 0 and `irq_id` is 7'h7F.
- R5: Basic bits 0 to 7 have the highest priority; the lowest set one wins and gives bank 0 with the bit number as line.
- R6: With no basic bit set, bank 1 shortcut bits 10 to 14 win; bit 10+k maps to line 7, 9, 10, 18, 19 for k = 0..4, in bank 1. Lowest set bit wins.
- R7: With no basic or bank 1 shortcut bit set, bank 2 shortcut bits 15 to 20 win; bit 15+k maps to line 21, 22, 23, 24, 25, 30 for k = 0..5, in bank 2.
- R8: With no basic or shortcut bit set, cascade bit 8 selects bank 1 and the line is the lowest set bit of the bank 1 word.
- R9: Cascade bit 9 has the lowest priority, selects bank 2 and the line is the lowest set bit of the bank 2 word.
- R10: When the winning cascade bit points to a bank word that is all zeros, the output is invalid (7'h7F, valid 0), even if the other cascade bit and its bank hold pending lines.
- R11: A bank word has no effect unless its cascade bit is the winning source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sum_word | input | 32 | Summary pending word (basic, cascade and shortcut bits) |
| bank1_word | input | 32 | Full pending word of bank 1 |
| bank2_word | input | 32 | Full pending word of bank 2 |
| irq_id | output | 7 | Registered identifier: bank in 6:5, line in 4:0 |
| irq_valid | output | 1 | Registered flag, 1 when `irq_id` names a pending line |

## Verification
Every shortcut bit is driven alone so that a wrong or shifted table entry, or a bank 2 shortcut reported under bank 1, shows up as a wrong line. Pairs that straddle group borders (a basic bit with a shortcut, bank 1 with bank 2 shortcuts, bank 2 shortcut with cascade bit 8, both cascade bits) catch a priority order built on plain bit position. A winning cascade bit with an empty bank word, and bank words loaded while their cascade bit is clear, catch a design that falls through to the next source or leaks bank contents. High summary bits alone catch a resolver that considers the whole word.

// File: rtl/pir_pkg.sv
package pir_pkg;

  localparam int BANK_W    = 32;
  localparam int LINE_W    = $clog2(BANK_W);
  localparam int BANKSEL_W = 2;
  localparam int ID_W      = BANKSEL_W + LINE_W;

  // summary word layout
  localparam int BASIC_LO  = 0;
  localparam int BASIC_N   = 8;
  localparam int CASC1_BIT = 8;
  localparam int CASC2_BIT = 9;
  localparam int SC_LO     = 10;
  localparam int SC1_N     = 5;
  localparam int SC2_N     = 6;
  localparam int SC_N      = SC1_N + SC2_N;
  localparam int SC_IDX_W  = $clog2(SC_N);
  localparam int BASIC_IDX_W = $clog2(BASIC_N);
  localparam int USED_TOP  = SC_LO + SC_N - 1;

  localparam logic [ID_W-1:0] ID_NONE = '1;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_BASIC, SRC_SC, SRC_CASC1, SRC_CASC2, SRC_EMPTY
  } pir_src_e;

  function automatic logic [ID_W-1:0] make_id(input logic [BANKSEL_W-1:0] bank,
                                              input logic [LINE_W-1:0] line);
    return {bank, line};
  endfunction

  // home line of shortcut number k
  function automatic logic [LINE_W-1:0] sc_home_line(input logic [SC_IDX_W-1:0] k);
    logic [LINE_W-1:0] r;
    case (k)
      4'd0:    r = 5'd7;
      4'd1:    r = 5'd9;
      4'd2:    r = 5'd10;
      4'd3:    r = 5'd18;
      4'd4:    r = 5'd19;
      4'd5:    r = 5'd21;
      4'd6:    r = 5'd22;
      4'd7:    r = 5'd23;
      4'd8:    r = 5'd24;
      4'd9:    r = 5'd25;
      4'd10:   r = 5'd30;
      default: r = '1;
    endcase
    return r;
  endfunction

  function automatic logic [BANKSEL_W-1:0] sc_home_bank(input logic [SC_IDX_W-1:0] k);
    return (int'(k) < SC1_N) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/pir_lsb_find.sv
module pir_lsb_find #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pir_shortcut_map.sv
module pir_shortcut_map
  import pir_pkg::*;
(
  input  logic [SC_IDX_W-1:0]  sc_idx,
  output logic [BANKSEL_W-1:0] home_bank,
  output logic [LINE_W-1:0]    home_line
);
  assign home_bank = sc_home_bank(sc_idx);
  assign home_line = sc_home_line(sc_idx);
endmodule

// File: rtl/pir_select.sv
module pir_select
  import pir_pkg::*;
(
  input  logic                   basic_hit,
  input  logic [BASIC_IDX_W-1:0] basic_idx,
  input  logic                   sc_hit,
  input  logic [BANKSEL_W-1:0]   sc_bank,
  input  logic [LINE_W-1:0]      sc_line,
  input  logic                   casc1,
  input  logic                   casc2,
  input  logic                   b1_hit,
  input  logic [LINE_W-1:0]      b1_idx,
  input  logic                   b2_hit,
  input  logic [LINE_W-1:0]      b2_idx,
  output pir_src_e               src,
  output logic                   nxt_valid,
  output logic [ID_W-1:0]        nxt_id
);
  always_comb begin
    src       = SRC_NONE;
    nxt_valid = 1'b0;
    nxt_id    = ID_NONE;
    if (basic_hit) begin
      src       = SRC_BASIC;
      nxt_valid = 1'b1;
      nxt_id    = make_id(2'd0, LINE_W'(basic_idx));
    end else if (sc_hit) begin
      src       = SRC_SC;
      nxt_valid = 1'b1;
      nxt_id    = make_id(sc_bank, sc_line);
    end else if (casc1) begin
      if (b1_hit) begin
        src       = SRC_CASC1;
        nxt_valid = 1'b1;
        nxt_id    = make_id(2'd1, b1_idx);
      end else begin
        src = SRC_EMPTY;
      end
    end else if (casc2) begin
      if (b2_hit) begin
        src       = SRC_CASC2;
        nxt_valid = 1'b1;
        nxt_id    = make_id(2'd2, b2_idx);
      end else begin
        src = SRC_EMPTY;
      end
    end
  end
endmodule

// File: rtl/pir_resolver.sv
module pir_resolver
  import pir_pkg::*;
#(
  parameter int SUM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SUM_W-1:0]  sum_word,
  input  logic [BANK_W-1:0] bank1_word,
  input  logic [BANK_W-1:0] bank2_word,
  output logic [ID_W-1:0]   irq_id,
  output logic              irq_valid
);
  localparam int NBANK = 2;

  // named internal events
  logic                   basic_hit;
  logic [BASIC_IDX_W-1:0] basic_idx;
  logic                   sc_hit;
  logic [SC_IDX_W-1:0]    sc_idx;
  logic [BANKSEL_W-1:0]   sc_bank;
  logic [LINE_W-1:0]      sc_line;
  logic [NBANK-1:0]       bank_hit;
  logic [LINE_W-1:0]      bank_idx [NBANK];
  pir_src_e               win_src;
  logic                   nxt_valid;
  logic [ID_W-1:0]        nxt_id;
  logic                   unused_hi;

  assign unused_hi = ^sum_word[SUM_W-1:USED_TOP+1];

  pir_lsb_find #(.W(BASIC_N)) u_basic (
    .vec (sum_word[BASIC_LO +: BASIC_N]),
    .hit (basic_hit),
    .idx (basic_idx)
  );

  pir_lsb_find #(.W(SC_N)) u_sc (
    .vec (sum_word[SC_LO +: SC_N]),
    .hit (sc_hit),
    .idx (sc_idx)
  );

  pir_shortcut_map u_map (
    .sc_idx    (sc_idx),
    .home_bank (sc_bank),
    .home_line (sc_line)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK_W-1:0] word;
    assign word = (b == 0) ? bank1_word : bank2_word;
    pir_lsb_find #(.W(BANK_W)) u_bank (
      .vec (word),
      .hit (bank_hit[b]),
      .idx (bank_idx[b])
    );
  end

  pir_select u_sel (
    .basic_hit (basic_hit),
    .basic_idx (basic_idx),
    .sc_hit    (sc_hit),
    .sc_bank   (sc_bank),
    .sc_line   (sc_line),
    .casc1     (sum_word[CASC1_BIT]),
    .casc2     (sum_word[CASC2_BIT]),
    .b1_hit    (bank_hit[0]),
    .b1_idx    (bank_idx[0]),
    .b2_hit    (bank_hit[1]),
    .b2_idx    (bank_idx[1]),
    .src       (win_src),
    .nxt_valid (nxt_valid),
    .nxt_id    (nxt_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_id    <= ID_NONE;
    end else begin
      irq_valid <= nxt_valid;
      irq_id    <= nxt_id;
    end
  end

  // R1: reset result
  a_r1_reset_invalid: assert property (@(posedge clk)
    $past(rst) |-> (!irq_valid && irq_id == ID_NONE));

  // R4: an invalid result always carries the all-ones identifier
  a_r4_invalid_ones: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> irq_id == ID_NONE);

  // R2: bank field of a valid identifier never exceeds 2
  a_r2_bank_range: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_id[ID_W-1 -: BANKSEL_W] != 2'd3);

  // R5: any basic bit gives a bank 0 result one cycle later
  a_r5_basic_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|sum_word[BASIC_LO +: BASIC_N]))
      |-> (irq_valid && irq_id[ID_W-1 -: BANKSEL_W] == 2'd0));

  // R6: bank 1 shortcut without basic bits gives bank 1
  a_r6_sc1_bank: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sum_word[BASIC_LO +: BASIC_N] == '0)
      && $past(|sum_word[SC_LO +: SC1_N]))
      |-> (irq_valid && irq_id[ID_W-1 -: BANKSEL_W] == 2'd1));

  // R10: winning cascade 1 with empty bank 1 word is invalid
  a_r10_empty_casc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sum_word[BASIC_LO +: BASIC_N] == '0)
      && $past(sum_word[SC_LO +: SC_N] == '0) && $past(sum_word[CASC1_BIT])
      && $past(bank1_word == '0))
      |-> !irq_valid);

  // R3: with nothing below bit 21 set, the result is invalid
  a_r3_high_ignored: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sum_word[USED_TOP:0] == '0)) |-> !irq_valid);

endmodule

// File: tb/pir_resolver_tb.sv
module pir_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sum_word = '0;
  logic [31:0] bank1_word = '0;
  logic [31:0] bank2_word = '0;
  logic [6:0]  irq_id;
  logic        irq_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pir_resolver dut_i (
    .clk        (clk),
    .rst        (rst),
    .sum_word   (sum_word),
    .bank1_word (bank1_word),
    .bank2_word (bank2_word),
    .irq_id     (irq_id),
    .irq_valid  (irq_valid)
  );

  function automatic int lowest(input logic [31:0] w);
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return -1;
  endfunction

  function automatic int sc_line_model(input int k);
    int tbl [11] = '{7, 9, 10, 18, 19, 21, 22, 23, 24, 25, 30};
    return tbl[k];
  endfunction

  // returns {valid, id}
  function automatic logic [7:0] model(input logic [31:0] s,
                                       input logic [31:0] b1,
                                       input logic [31:0] b2);
    int n;
    for (int i = 0; i < 8; i++) if (s[i]) return {1'b1, 2'd0, 5'(i)};
    for (int k = 0; k < 11; k++)
      if (s[10 + k]) return {1'b1, (k < 5) ? 2'd1 : 2'd2, 5'(sc_line_model(k))};
    if (s[8]) begin
      n = lowest(b1);
      return (n < 0) ? 8'h7F : {1'b1, 2'd1, 5'(n)};
    end
    if (s[9]) begin
      n = lowest(b2);
      return (n < 0) ? 8'h7F : {1'b1, 2'd2, 5'(n)};
    end
    return 8'h7F;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if ({irq_valid, irq_id} !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b id=%02h, expected valid=%0b id=%02h",
               req, irq_valid, irq_id, exp[7], exp[6:0]);
    end
  endtask

  // drive at falling edge, result registered at next rising edge, sample at next falling edge
  task automatic apply(input string req, input logic [31:0] s,
                       input logic [31:0] b1, input logic [31:0] b2);
    sum_word = s; bank1_word = b1; bank2_word = b2;
    @(negedge clk);
    check(req, model(s, b1, b2));
  endtask

  task automatic apply_exp(input string req, input logic [31:0] s,
                           input logic [31:0] b1, input logic [31:0] b2,
                           input logic [7:0] exp);
    sum_word = s; bank1_word = b1; bank2_word = b2;
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    int unsigned seed;
    logic [31:0] s, b1, b2;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h7F);
    rst = 1'b0;
    apply_exp("R4 all zero", 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h7F);
    apply_exp("R3 high bits only", 32'hFFE0_0000, 32'h1, 32'h1, 8'h7F);
    apply_exp("R2 latency basic 3", 32'h0000_0008, 0, 0, 8'h83);
    apply_exp("R5 basic lowest", 32'h0000_00A0, 0, 0, 8'h85);
    apply_exp("R5 basic beats shortcut", 32'h001F_FC80, 32'h1, 32'h1, 8'h87);
    for (int k = 0; k < 11; k++)
      apply((k < 5) ? "R6 single shortcut" : "R7 single shortcut",
            32'h1 << (10 + k), 32'h0, 32'h0);
    apply_exp("R6 sc1 line 9 (bit 11)", 32'h0000_0800, 0, 0, 8'hA9);
    apply_exp("R7 sc2 line 30 (bit 20)", 32'h0010_0000, 0, 0, 8'hDE);
    apply_exp("R6 sc1 beats sc2", 32'h0018_4000, 0, 0, 8'hB3);
    apply_exp("R7 sc2 beats cascade", 32'h0002_0300, 32'h1, 32'h1, 8'hD7);
    apply_exp("R8 cascade 1", 32'h0000_0300, 32'h0000_1000, 32'h1, 8'hAC);
    apply_exp("R9 cascade 2 top bit", 32'h0000_0200, 32'h0, 32'h8000_0000, 8'hDF);
    apply_exp("R10 empty bank 1", 32'h0000_0300, 32'h0, 32'h0000_0004, 8'h7F);
    apply_exp("R10 empty bank 2", 32'h0000_0200, 32'h0000_0004, 32'h0, 8'h7F);
    apply_exp("R11 bank words without cascade", 32'h0000_0000, 32'h0000_0010, 32'h0000_0020, 8'h7F);
    apply_exp("R11 bank 2 ignored on cascade 1", 32'h0000_0100, 32'h0000_0040, 32'h0000_0001, 8'hA6);
    for (int n = 0; n < 2000; n++) begin
      s  = $urandom;
      b1 = $urandom;
      b2 = $urandom;
      case (n % 5)
        0: s = s & 32'hFFFF_FF00;
        1: s = s & 32'hFFE0_03FF;
        2: begin s = s & 32'hFFE0_0300; b1 = (n % 3 == 0) ? 32'h0 : b1 & (b1 - 1); end
        3: begin s = s & 32'hFFE0_0200; b2 = b2 & $urandom & $urandom; end
        default: ;
      endcase
      apply("R2 random", s, b1, b2);
    end
    sum_word = 32'h0000_0001;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset with inputs", 8'h7F);
    rst = 1'b0;
    @(negedge clk);
    check("R5 after reset", 8'h80);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule